// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block owns the 13-bit fetch address of a small accumulator-style microcontroller core. Every clock is one instruction cycle. The decoder gives it a two-bit operation code for the instruction that is executing. It also gives it an 11-bit immediate, the page latch register and the value of the bit under test. From these the sequencer picks the next fetch address: the following word, a subroutine target, a return address taken from an internal hardware stack, or a step past a skipped word.

The fetch stage runs one word ahead of execution, so the word already fetched must be thrown away when the program counter is redirected. Calls, returns and taken skips raise `stall_o` in the cycle they execute. In the cycle after that, `nop_o` tells the core to execute a forced no-operation instead of the word it fetched. The program counter still advances during that forced cycle, so a taken skip resumes two words after the skip instruction. A call target is built from the immediate and two page bits taken from the latch register. The return stack has eight entries and is circular.

Top module: `pc_sequencer`

## Requirements
- R1: After reset `fetch_addr_o` is 0, `nop_o` is 0 and the return stack is empty. A return executed before any call loads address 0.
- R2: Operation code 2'b00 (next) advances `fetch_addr_o` by one on the following edge, wrapping from 8191 to 0, with no stall and no forced NOP.
- R3: Operation code 2'b01 (call) loads `fetch_addr_o` with `page_i[4:3]` in bits 12:11 and `imm_i` in bits 10:0. All other latch bits are ignored.
- R4: A call pushes the `fetch_addr_o` value of its own execute cycle (the call's address plus one) onto the return stack before the program counter changes.
- R5: A call, a return and a taken skip each raise `stall_o` in their execute cycle, and `nop_o` is high for exactly the one following cycle.
- R6: Operation code 2'b10 (return) loads all 13 bits of `fetch_addr_o` from the top of the stack and pops it.
- R7: Operation code 2'b11 (skip if set) with `bit_i` = 0 behaves like next: advance by one, no stall, no forced NOP.
- R8: Skip if set with `bit_i` = 1 forces a NOP into the next cycle. After that cycle `fetch_addr_o` is the skip's own `fetch_addr_o` plus two.
- R9: While `nop_o` is high, `op_i` is ignored: `stall_o` stays low, nothing is pushed or popped, and `fetch_addr_o` advances by one.
- R10: The stack holds 8 entries. A ninth push overwrites the oldest entry without any flag. Eight returns then deliver the eight newest addresses in last-in-first-out order, and a ninth return delivers the newest one again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one instruction cycle per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Decoded operation: 00 next, 01 call, 10 return, 11 skip if set |
| imm_i | input | 11 | Call target within the page |
| page_i | input | 8 | Page latch register; bits 4:3 select the page |
| bit_i | input | 1 | Value of the bit tested by skip if set |
| fetch_addr_o | output | 13 | Current fetch address (program counter) |
| nop_o | output | 1 | Current cycle executes a forced NOP |
| stall_o | output | 1 | Executing operation takes a second cycle |

## Verification
A wrong stack pointer or a corrupted stack entry cannot be seen until a return executes. The bench therefore nests nine calls and then unwinds them, so every slot and the pointer wrap show up at `fetch_addr_o` one edge after each return. A flush flag that sticks or is dropped shows at `nop_o` in the cycle right after a two-cycle operation. It also shows one edge later as a fetch address that is off by one. A bad page or immediate merge shows in the fetch address one edge after the call.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    OP_NEXT    = 2'b00,
    OP_CALL    = 2'b01,
    OP_RET     = 2'b10,
    OP_SKIPSET = 2'b11
  } op_e;
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int SP_W = $clog2(DEPTH);

  logic [W-1:0]    mem_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] top_idx;

  // sp_q is the next free slot; DEPTH is a power of two so indices wrap
  assign top_idx = sp_q - SP_W'(1);
  assign top_o   = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[sp_q] <= push_data_i;
      sp_q        <= sp_q + SP_W'(1);
    end else if (pop_i) begin
      sp_q <= top_idx;
    end
  end

  assert_push_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_data_i));

  assert_push_pop_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int IMM_W   = 11,
  parameter int LATCH_W = 8,
  parameter int PAGE_LO = 3
) (
  input  logic [PC_W-1:0]    pc_i,
  input  logic               flush_i,
  input  op_e                op_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [LATCH_W-1:0] page_i,
  input  logic               bit_i,
  input  logic [PC_W-1:0]    tos_i,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               flush_next_o,
  output logic               push_o,
  output logic               pop_o,
  output logic               stall_o
);
  localparam int PAGE_W  = PC_W - IMM_W;
  localparam int PAGE_HI = PAGE_LO + PAGE_W - 1;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] call_tgt;

  assign pc_inc   = pc_i + PC_W'(1);
  assign call_tgt = {page_i[PAGE_HI:PAGE_LO], imm_i};

  always_comb begin
    next_pc_o    = pc_inc;
    flush_next_o = 1'b0;
    push_o       = 1'b0;
    pop_o        = 1'b0;
    if (!flush_i) begin
      unique case (op_i)
        OP_CALL: begin
          next_pc_o    = call_tgt;
          flush_next_o = 1'b1;
          push_o       = 1'b1;
        end
        OP_RET: begin
          next_pc_o    = tos_i;
          flush_next_o = 1'b1;
          pop_o        = 1'b1;
        end
        OP_SKIPSET: flush_next_o = bit_i;
        default: ;
      endcase
    end
  end

  assign stall_o = flush_next_o;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int IMM_W   = 11,
  parameter int LATCH_W = 8,
  parameter int PAGE_LO = 3,
  parameter int DEPTH   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         op_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [LATCH_W-1:0] page_i,
  input  logic               bit_i,
  output logic [PC_W-1:0]    fetch_addr_o,
  output logic               nop_o,
  output logic               stall_o
);
  localparam int PAGE_W  = PC_W - IMM_W;
  localparam int PAGE_HI = PAGE_LO + PAGE_W - 1;

  logic [PC_W-1:0] pc_q, pc_d, tos;
  logic            flush_q, flush_d;
  logic            push, pop;
  op_e             op;

  assign op = op_e'(op_i);

  pcs_next_pc #(
    .PC_W(PC_W), .IMM_W(IMM_W), .LATCH_W(LATCH_W), .PAGE_LO(PAGE_LO)
  ) u_next (
    .pc_i(pc_q), .flush_i(flush_q), .op_i(op), .imm_i(imm_i),
    .page_i(page_i), .bit_i(bit_i), .tos_i(tos),
    .next_pc_o(pc_d), .flush_next_o(flush_d),
    .push_o(push), .pop_o(pop), .stall_o(stall_o)
  );

  // return address is the prefetched word: call address + 1
  pcs_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_data_i(pc_q), .top_o(tos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      flush_q <= flush_d;
    end
  end

  assign fetch_addr_o = pc_q;
  assign nop_o        = flush_q;

  assert_call_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 && !nop_o) |=>
      fetch_addr_o == {$past(page_i[PAGE_HI:PAGE_LO]), $past(imm_i)});

  assert_stall_then_nop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> nop_o);

  assert_nop_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |=> !nop_o);

  assert_nop_advance_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(1));

  assert_nop_no_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_o |-> !stall_o);

  assert_skip_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11 && !bit_i && !nop_o) |=>
      (!nop_o && fetch_addr_o == $past(fetch_addr_o) + PC_W'(1)));
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [12:0] pc;
    logic        nop;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [10:0] imm_i = '0;
  logic [7:0]  page_i = '0;
  logic        bit_i = 1'b0;
  logic [12:0] fetch_addr_o;
  logic        nop_o, stall_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t        q[$];
  logic [12:0] mpc = '0;
  logic        mflush = 1'b0;
  logic [12:0] mstk[8];
  int          msp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .imm_i(imm_i),
    .page_i(page_i), .bit_i(bit_i), .fetch_addr_o(fetch_addr_o),
    .nop_o(nop_o), .stall_o(stall_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: applies one operation, checks stall, pushes expected state
  task automatic step(input logic [1:0] op, input logic [10:0] imm,
                      input logic [7:0] page, input logic b, input string tag);
    logic        es;
    logic [12:0] npc;
    logic        nfl;
    exp_t        e;
    @(negedge clk);
    op_i = op; imm_i = imm; page_i = page; bit_i = b;
    #1;
    es = !mflush && (op == 2'b01 || op == 2'b10 || (op == 2'b11 && b));
    check({tag, " stall"}, 32'(stall_o), 32'(es));
    npc = mpc + 13'd1;
    nfl = 1'b0;
    if (!mflush) begin
      case (op)
        2'b01: begin
          mstk[msp] = mpc; msp = (msp + 1) % 8;
          npc = {page[4:3], imm}; nfl = 1'b1;
        end
        2'b10: begin
          msp = (msp + 7) % 8; npc = mstk[msp]; nfl = 1'b1;
        end
        2'b11: nfl = b;
        default: ;
      endcase
    end
    mpc = npc; mflush = nfl;
    e.pc = npc; e.nop = nfl; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares registered outputs after each edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " pc"}, 32'(fetch_addr_o), 32'(e.pc));
      check({e.tag, " nop"}, 32'(nop_o), 32'(e.nop));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mstk[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1 reset pc", 32'(fetch_addr_o), 0);
    check("R1 reset nop", 32'(nop_o), 0);
    check("R1 reset stall", 32'(stall_o), 0);
    step(2'b10, 11'h0, 8'h0, 0, "R1 empty return");
    step(2'b00, 11'h0, 8'h0, 0, "R5 nop after return");
    for (int i = 0; i < 3; i++) step(2'b00, 11'h7ff, 8'hff, 1, "R2 next");
    step(2'b11, 11'h0, 8'h0, 0, "R7 skip clear");
    step(2'b11, 11'h0, 8'h0, 1, "R8 skip set");
    step(2'b01, 11'h555, 8'h18, 1, "R9 call ignored in nop");
    step(2'b00, 11'h0, 8'h0, 0, "R8 after skip");
    step(2'b01, 11'h123, 8'he7, 0, "R3 call page0 other bits set");
    step(2'b10, 11'h0, 8'h0, 0, "R9 return ignored in nop");
    step(2'b01, 11'h456, 8'h10, 0, "R3 call page2");
    step(2'b00, 11'h0, 8'h0, 0, "R5 nop after call");
    step(2'b00, 11'h0, 8'h0, 0, "R2 next in sub");
    step(2'b10, 11'h0, 8'h0, 0, "R6 return inner");
    step(2'b00, 11'h0, 8'h0, 0, "R5 nop after return");
    step(2'b10, 11'h0, 8'h0, 0, "R4 return outer");
    step(2'b00, 11'h0, 8'h0, 0, "R5 nop");
    step(2'b01, 11'h7ff, 8'h18, 0, "R3 call top");
    step(2'b00, 11'h0, 8'h0, 0, "R2 wrap in nop");
    step(2'b00, 11'h0, 8'h0, 0, "R2 next after wrap");
    for (int i = 0; i < 9; i++) begin
      step(2'b01, 11'(16 * i + 5), 8'(i << 3), 0, "R10 nested call");
      step(2'b00, 11'h0, 8'h0, 0, "R10 nop");
      step(2'b00, 11'h0, 8'h0, 0, "R10 body");
    end
    for (int i = 0; i < 9; i++) begin
      step(2'b10, 11'h0, 8'h0, 0, "R10 unwind");
      step(2'b00, 11'h0, 8'h0, 0, "R10 nop");
    end
    step(2'b00, 11'h0, 8'h0, 0, "R2 final");
    @(negedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule